// File: doc/BRIEF.md
# USB-PD Transmit Outcome and Interrupt Controller

This block tracks what happens to each message the PD framer sends. A register write starts a transmission. The block then waits for the framer to report the end of the frame, and starts a response window of `TMO_CYC` clock cycles (about 1 ms at the default). If an acknowledgment arrives inside the window, the message has succeeded. If the window runs out, the block retransmits, up to a programmable number of retries, and then declares a retry failure. A collision on the line ends the attempt at once.

The block can also ask the line driver to send hard-reset signalling, and it records hard resets that the receiver detects. After either one, the protocol side stays frozen until software issues a protocol-reset command. Outcomes are latched in two pending banks. Reading a bank clears it. Each bank has a per-bit mask, and a global disable sits over both. Together they drive a single active-low interrupt pin.

Top module: `pd_txr_irq`

Register addresses: 0 control, 1 retry, 2 command, 3 mask A, 4 mask B, 5 pending A, 6 pending B. Pending A bits: 0 acknowledged, 1 retry fail, 2 collision, 3 hard reset sent, 4 hard reset received. Pending B bits: 0 acknowledgment sent.

## Requirements
- R1: After reset, `irq_n` is 1, `tx_start` and `hr_send` are 0, the retry register reads 0x06 (retries disabled, count 3), the control register reads 0x20 (global disable set), and all mask and pending registers read 0.
- R2: Writing 1 to control bit 0 while idle raises `tx_start` for exactly one cycle, in the cycle after the write. The same write is ignored while a message or a hard reset is in progress, and while frozen.
- R3: An acknowledgment (`gcrc_rx`) that arrives within `TMO_CYC` cycles after `frame_sent` sets pending A bit 0 and ends the transfer with no further `tx_start`.
- R4: When the window expires with no acknowledgment, retry bit 0 is 1 and fewer retries than the count in retry bits 2:1 have been made, `tx_start` pulses again. A transfer sends at most count+1 frames, and exactly one when the count is 0 or retries are disabled.
- R5: When the window expires after the last permitted attempt, pending A bit 1 is set and the block returns to idle.
- R6: `line_coll` while waiting for the end of the frame or for the acknowledgment sets pending A bit 2 and ends the transfer without a retry.
- R7: Writing 1 to retry bit 6 (when neither frozen nor already signalling) pulses `hr_send` for one cycle in the next cycle and abandons any message in flight. A later `hr_done` sets pending A bit 3 and freezes the block.
- R8: `hr_rx` sets pending A bit 4, cancels any pulse that cycle and freezes the block. While frozen, no `tx_start` or `hr_send` is produced until command bit 1 is written, which returns the block to idle.
- R9: `ack_done` sets pending B bit 0 in every state.
- R10: A read returns its data in the cycle after `reg_rd` (0 when no read). Reading a pending register returns its bits and clears them, but an event arriving in the same cycle as the read stays pending.
- R11: `irq_n` is 0 exactly when, in the previous cycle, some pending bit had its mask bit at 0 and control bit 5 was 0. Masked events are still latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| frame_sent | input | 1 | Framer finished sending a frame |
| line_coll | input | 1 | Collision detected on the line |
| gcrc_rx | input | 1 | Acknowledgment received for the sent message |
| hr_done | input | 1 | Hard-reset signalling finished |
| hr_rx | input | 1 | Hard reset received |
| ack_done | input | 1 | Automatic acknowledgment of a received packet finished |
| tx_start | output | 1 | Pulse: start (re)sending the queued frame |
| hr_send | output | 1 | Pulse: start hard-reset signalling |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong internal state first shows on `tx_start` or `hr_send`. A stuck retry counter or response timer gives an extra or missing retransmission one window late. A state that should be frozen restarts a frame in the cycle after a write. A bad pending or mask bit shows on `irq_n` one cycle after the event or the read, and in the next read of that bank. The bench's reference model predicts all four outputs on every cycle, so any of these faults is caught in the cycle where it first shows at a port.

// File: rtl/pd_txr_pkg.sv
`timescale 1ns/1ps
package pd_txr_pkg;
  localparam int DW    = 8;
  localparam int NBANK = 2;

  // register addresses
  localparam int A_CTL  = 0;
  localparam int A_RTY  = 1;
  localparam int A_CMD  = 2;
  localparam int A_MSK0 = 3;
  localparam int A_PND0 = A_MSK0 + NBANK;
  localparam int NREG   = A_PND0 + NBANK;
  localparam int AW     = $clog2(NREG);

  // field positions
  localparam int CTL_GO    = 0;
  localparam int CTL_GMASK = 5;
  localparam int RTY_EN    = 0;
  localparam int RTY_CNT   = 1;
  localparam int RTY_HR    = 6;
  localparam int CMD_PDRST = 1;

  // bank A events
  localparam int EV_OK    = 0;
  localparam int EV_FAIL  = 1;
  localparam int EV_COLL  = 2;
  localparam int EV_HRS   = 3;
  localparam int EV_HRR   = 4;
  // bank B events
  localparam int EVB_ACK  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_ACKW, ST_HRST, ST_HALT
  } txst_e;
endpackage

// File: rtl/pd_txr_irqbank.sv
`timescale 1ns/1ps
module pd_txr_irqbank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o
);
  // read-to-clear; a same-cycle event survives the clear
  always_ff @(posedge clk) begin
    if (rst)        pend_o <= '0;
    else if (clr_i) pend_o <= ev_i;
    else            pend_o <= pend_o | ev_i;
  end
endmodule

// File: rtl/pd_txr_regs.sv
`timescale 1ns/1ps
module pd_txr_regs import pd_txr_pkg::*; #(
  parameter int CNT_W     = 2,
  parameter int RETRY_DEF = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_wr,
  input  logic                      reg_rd,
  input  logic [AW-1:0]             reg_addr,
  input  logic [DW-1:0]             reg_wdata,
  input  logic [NBANK-1:0][DW-1:0]  pend_i,
  output logic [DW-1:0]             reg_rdata,
  output logic                      gmask,
  output logic                      retry_en,
  output logic [CNT_W-1:0]          retry_cnt,
  output logic [NBANK-1:0][DW-1:0]  mask_o,
  output logic                      tx_go,
  output logic                      hr_go,
  output logic                      pd_rst,
  output logic [NBANK-1:0]          rd_clr
);
  logic wr_ctl, wr_rty, wr_cmd;
  logic [DW-1:0] rd_val;

  assign wr_ctl = reg_wr && (reg_addr == AW'(A_CTL));
  assign wr_rty = reg_wr && (reg_addr == AW'(A_RTY));
  assign wr_cmd = reg_wr && (reg_addr == AW'(A_CMD));

  assign tx_go  = wr_ctl && reg_wdata[CTL_GO];
  assign hr_go  = wr_rty && reg_wdata[RTY_HR];
  assign pd_rst = wr_cmd && reg_wdata[CMD_PDRST];

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask     <= 1'b1;
      retry_en  <= 1'b0;
      retry_cnt <= CNT_W'(RETRY_DEF);
    end else begin
      if (wr_ctl) gmask <= reg_wdata[CTL_GMASK];
      if (wr_rty) begin
        retry_en  <= reg_wdata[RTY_EN];
        retry_cnt <= reg_wdata[RTY_CNT +: CNT_W];
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                         mask_o[b] <= '0;
      else if (reg_wr && reg_addr == AW'(A_MSK0 + b))  mask_o[b] <= reg_wdata;
    end
    assign rd_clr[b] = reg_rd && (reg_addr == AW'(A_PND0 + b));
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == AW'(A_CTL)) rd_val[CTL_GMASK] = gmask;
    if (reg_addr == AW'(A_RTY)) begin
      rd_val[RTY_EN]            = retry_en;
      rd_val[RTY_CNT +: CNT_W]  = retry_cnt;
    end
    for (int b = 0; b < NBANK; b++) begin
      if (reg_addr == AW'(A_MSK0 + b)) rd_val = mask_o[b];
      if (reg_addr == AW'(A_PND0 + b)) rd_val = pend_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= reg_rd ? rd_val : '0;
  end
endmodule

// File: rtl/pd_txr_fsm.sv
`timescale 1ns/1ps
module pd_txr_fsm import pd_txr_pkg::*; #(
  parameter int TMO_CYC = 200000,
  parameter int CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_go,
  input  logic             hr_go,
  input  logic             pd_rst,
  input  logic             retry_en,
  input  logic [CNT_W-1:0] retry_cnt,
  input  logic             frame_sent,
  input  logic             line_coll,
  input  logic             gcrc_rx,
  input  logic             hr_done,
  input  logic             hr_rx,
  output logic             tx_start,
  output logic             hr_send,
  output logic [DW-1:0]    ev_a
);
  localparam int TW = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYC - 1);

  txst_e            st, st_n;
  logic [TW-1:0]    tmr, tmr_n;
  logic [CNT_W-1:0] tries, tries_n;
  logic             go_tx, go_hr;

  always_comb begin
    st_n    = st;
    tmr_n   = tmr;
    tries_n = tries;
    go_tx   = 1'b0;
    go_hr   = 1'b0;
    ev_a    = '0;
    case (st)
      ST_IDLE: begin
        if (hr_go) begin
          go_hr = 1'b1; st_n = ST_HRST;
        end else if (tx_go) begin
          go_tx = 1'b1; st_n = ST_SEND; tries_n = '0;
        end
      end
      ST_SEND: begin
        if (hr_go) begin
          go_hr = 1'b1; st_n = ST_HRST;
        end else if (line_coll) begin
          ev_a[EV_COLL] = 1'b1; st_n = ST_IDLE;
        end else if (frame_sent) begin
          st_n = ST_ACKW; tmr_n = '0;
        end
      end
      ST_ACKW: begin
        if (hr_go) begin
          go_hr = 1'b1; st_n = ST_HRST;
        end else if (gcrc_rx) begin
          ev_a[EV_OK] = 1'b1; st_n = ST_IDLE;
        end else if (line_coll) begin
          ev_a[EV_COLL] = 1'b1; st_n = ST_IDLE;
        end else if (tmr == TMO_LAST) begin
          if (retry_en && (tries < retry_cnt)) begin
            tries_n = tries + 1'b1; go_tx = 1'b1; st_n = ST_SEND;
          end else begin
            ev_a[EV_FAIL] = 1'b1; st_n = ST_IDLE;
          end
        end else begin
          tmr_n = tmr + 1'b1;
        end
      end
      ST_HRST: begin
        if (hr_done) begin
          ev_a[EV_HRS] = 1'b1; st_n = ST_HALT;
        end
      end
      default: ;
    endcase
    // a received hard reset overrides the transfer outcome
    if (hr_rx) begin
      ev_a = '0; ev_a[EV_HRR] = 1'b1;
      st_n = ST_HALT; go_tx = 1'b0; go_hr = 1'b0;
    end
    if (pd_rst) begin
      st_n = ST_IDLE; go_tx = 1'b0; go_hr = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tmr      <= '0;
      tries    <= '0;
      tx_start <= 1'b0;
      hr_send  <= 1'b0;
    end else begin
      st       <= st_n;
      tmr      <= tmr_n;
      tries    <= tries_n;
      tx_start <= go_tx;
      hr_send  <= go_hr;
    end
  end
endmodule

// File: rtl/pd_txr_irq.sv
`timescale 1ns/1ps
module pd_txr_irq import pd_txr_pkg::*; #(
  parameter int TMO_CYC   = 200000,
  parameter int CNT_W     = 2,
  parameter int RETRY_DEF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          frame_sent,
  input  logic          line_coll,
  input  logic          gcrc_rx,
  input  logic          hr_done,
  input  logic          hr_rx,
  input  logic          ack_done,
  output logic          tx_start,
  output logic          hr_send,
  output logic          irq_n
);
  logic [NBANK-1:0][DW-1:0] ev, pend, mask;
  logic [NBANK-1:0]         rd_clr;
  logic [DW-1:0]            ev_a;
  logic                     gmask, retry_en, tx_go, hr_go, pd_rst, any_pend;
  logic [CNT_W-1:0]         retry_cnt;
  logic [NBANK*DW-1:0]      ev_flat, pend_flat;

  pd_txr_regs #(.CNT_W(CNT_W), .RETRY_DEF(RETRY_DEF)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_i(pend),
    .reg_rdata(reg_rdata), .gmask(gmask), .retry_en(retry_en),
    .retry_cnt(retry_cnt), .mask_o(mask), .tx_go(tx_go),
    .hr_go(hr_go), .pd_rst(pd_rst), .rd_clr(rd_clr)
  );

  pd_txr_fsm #(.TMO_CYC(TMO_CYC), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .tx_go(tx_go), .hr_go(hr_go), .pd_rst(pd_rst),
    .retry_en(retry_en), .retry_cnt(retry_cnt), .frame_sent(frame_sent),
    .line_coll(line_coll), .gcrc_rx(gcrc_rx), .hr_done(hr_done),
    .hr_rx(hr_rx), .tx_start(tx_start), .hr_send(hr_send), .ev_a(ev_a)
  );

  always_comb begin
    ev          = '0;
    ev[0]       = ev_a;
    ev[1][EVB_ACK] = ack_done;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_pend
    pd_txr_irqbank #(.W(DW)) u_bank (
      .clk(clk), .rst(rst), .ev_i(ev[b]), .clr_i(rd_clr[b]), .pend_o(pend[b])
    );
  end

  always_comb begin
    any_pend = 1'b0;
    for (int b = 0; b < NBANK; b++) any_pend = any_pend | (|(pend[b] & ~mask[b]));
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~(any_pend & ~gmask);
  end

  assign ev_flat   = ev;
  assign pend_flat = pend;
endmodule

// File: rtl/pd_txr_irq_chk.sv
`timescale 1ns/1ps
module pd_txr_irq_chk #(
  parameter int CNT_W = 2,
  parameter int FW    = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tx_start,
  input logic          hr_send,
  input logic          hr_rx,
  input logic          irq_n,
  input logic          gmask,
  input logic          tx_go,
  input logic [FW-1:0] ev_flat,
  input logic [FW-1:0] pend_flat
);
  logic [CNT_W+1:0] sends;

  always_ff @(posedge clk) begin
    if (rst)           sends <= '0;
    else if (tx_go)    sends <= '0;
    else if (tx_start) sends <= sends + 1'b1;
  end

  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_retry_bound_R4: assert property (@(posedge clk) disable iff (rst)
    sends <= (CNT_W+2)'(1 << CNT_W));

  assert_hr_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    hr_send |=> !hr_send);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
    !(tx_start && hr_send));

  assert_hrrx_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    hr_rx |=> (!tx_start && !hr_send));

  assert_event_latched_R10: assert property (@(posedge clk) disable iff (rst)
    (ev_flat != '0) |=> ((pend_flat & $past(ev_flat)) == $past(ev_flat)));

  assert_gmask_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    $past(gmask) |-> irq_n);
endmodule

bind pd_txr_irq pd_txr_irq_chk #(.CNT_W(CNT_W), .FW(pd_txr_pkg::NBANK*pd_txr_pkg::DW)) u_chk (
  .clk(clk), .rst(rst), .tx_start(tx_start), .hr_send(hr_send), .hr_rx(hr_rx),
  .irq_n(irq_n), .gmask(gmask), .tx_go(tx_go), .ev_flat(ev_flat), .pend_flat(pend_flat)
);

// File: tb/sim_pd_txr_irq.sv
`timescale 1ns/1ps
module sim_pd_txr_irq;
  localparam int TMO = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic frame_sent = 0, line_coll = 0, gcrc_rx = 0, hr_done = 0, hr_rx = 0, ack_done = 0;
  logic tx_start, hr_send, irq_n;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit live = 0, done = 0;

  always #2.5 clk = ~clk;

  pd_txr_irq #(.TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_sent(frame_sent),
    .line_coll(line_coll), .gcrc_rx(gcrc_rx), .hr_done(hr_done), .hr_rx(hr_rx),
    .ack_done(ack_done), .tx_start(tx_start), .hr_send(hr_send), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int       m_st = 0, m_tmr = 0, m_try = 0;
  bit       m_gm = 1, m_en = 0;
  bit [1:0] m_cnt = 3;
  bit [7:0] m_mask [2];
  bit [7:0] m_pend [2];
  bit [7:0] m_rd = 0;
  bit       m_irqn = 1, m_txs = 0, m_hrs = 0;

  always @(posedge clk) begin : model
    int nst, ntmr, ntry;
    bit gtx, ghr, go, hg, pdr, anyp;
    bit [7:0] ea, eb, rv;
    if (rst) begin
      m_st = 0; m_tmr = 0; m_try = 0; m_gm = 1; m_en = 0; m_cnt = 3;
      m_mask[0] = 0; m_mask[1] = 0; m_pend[0] = 0; m_pend[1] = 0;
      m_rd = 0; m_irqn = 1; m_txs = 0; m_hrs = 0;
    end else begin
      go  = reg_wr && reg_addr == 0 && reg_wdata[0];
      hg  = reg_wr && reg_addr == 1 && reg_wdata[6];
      pdr = reg_wr && reg_addr == 2 && reg_wdata[1];
      nst = m_st; ntmr = m_tmr; ntry = m_try; gtx = 0; ghr = 0; ea = 0; eb = 0;
      if (m_st == 0) begin
        if (hg) begin ghr = 1; nst = 3; end
        else if (go) begin gtx = 1; nst = 1; ntry = 0; end
      end else if (m_st == 1) begin
        if (hg) begin ghr = 1; nst = 3; end
        else if (line_coll) begin ea[2] = 1; nst = 0; end
        else if (frame_sent) begin nst = 2; ntmr = 0; end
      end else if (m_st == 2) begin
        if (hg) begin ghr = 1; nst = 3; end
        else if (gcrc_rx) begin ea[0] = 1; nst = 0; end
        else if (line_coll) begin ea[2] = 1; nst = 0; end
        else if (m_tmr == TMO - 1) begin
          if (m_en && m_try < int'(m_cnt)) begin ntry = m_try + 1; gtx = 1; nst = 1; end
          else begin ea[1] = 1; nst = 0; end
        end else ntmr = m_tmr + 1;
      end else if (m_st == 3) begin
        if (hr_done) begin ea[3] = 1; nst = 4; end
      end
      if (hr_rx) begin ea = 8'h10; nst = 4; gtx = 0; ghr = 0; end
      if (pdr) begin nst = 0; gtx = 0; ghr = 0; end
      if (ack_done) eb[0] = 1;
      case (reg_addr)
        3'd0: rv = {2'b0, m_gm, 5'b0};
        3'd1: rv = {5'b0, m_cnt, m_en};
        3'd3: rv = m_mask[0];
        3'd4: rv = m_mask[1];
        3'd5: rv = m_pend[0];
        3'd6: rv = m_pend[1];
        default: rv = 0;
      endcase
      m_rd = reg_rd ? rv : 8'h00;
      anyp = ((m_pend[0] & ~m_mask[0]) != 0) || ((m_pend[1] & ~m_mask[1]) != 0);
      m_irqn = !(anyp && !m_gm);
      m_pend[0] = (reg_rd && reg_addr == 5) ? ea : (m_pend[0] | ea);
      m_pend[1] = (reg_rd && reg_addr == 6) ? eb : (m_pend[1] | eb);
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_gm = reg_wdata[5];
          3'd1: begin m_en = reg_wdata[0]; m_cnt = reg_wdata[2:1]; end
          3'd3: m_mask[0] = reg_wdata;
          3'd4: m_mask[1] = reg_wdata;
          default: ;
        endcase
      end
      m_st = nst; m_tmr = ntmr; m_try = ntry; m_txs = gtx; m_hrs = ghr;
    end
  end

  always @(negedge clk) begin
    if (!rst && live) begin
      chk("R2 tx_start vs model", tx_start, m_txs);
      chk("R7 hr_send vs model", hr_send, m_hrs);
      chk("R11 irq_n vs model", irq_n, m_irqn);
      chk("R10 rdata vs model", reg_rdata, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected<20000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rdchk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    chk(tag, reg_rdata, exp);
  endtask

  // start a message, answer every tx_start with frame_sent, optional ack/collision/hard reset
  task automatic run_tx(input int ack_at, input int coll_at, input int hrx_at, output int starts);
    starts = 0;
    wr(3'd0, 8'h01);
    for (int n = 0; n < 100; n++) begin
      if (tx_start) begin starts++; frame_sent = 1; end
      if (n == ack_at)  gcrc_rx = 1;
      if (n == coll_at) line_coll = 1;
      if (n == hrx_at)  hr_rx = 1;
      @(negedge clk);
      frame_sent = 0; gcrc_rx = 0; line_coll = 0; hr_rx = 0;
    end
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 0;
    live = 1;
    step();

    // R1 reset state
    chk("R1 irq_n idle", irq_n, 1);
    chk("R1 tx_start idle", tx_start, 0);
    chk("R1 hr_send idle", hr_send, 0);
    rdchk(3'd1, 8'h06, "R1 retry register default");
    rdchk(3'd0, 8'h20, "R1 control default");
    rdchk(3'd5, 8'h00, "R1 pending A clear");
    rdchk(3'd3, 8'h00, "R1 mask A clear");

    wr(3'd0, 8'h00);
    wr(3'd1, 8'h07);

    // R3 acknowledged message
    run_tx(3, -1, -1, s);
    chk("R3 single send on ack", s, 1);
    chk("R11 irq asserted on pending", irq_n, 0);
    rdchk(3'd5, 8'h01, "R3 ack flag");
    step();
    chk("R11 irq released after clear", irq_n, 1);

    // R4 / R5 retries exhausted
    run_tx(-1, -1, -1, s);
    chk("R4 count 3 gives four sends", s, 4);
    rdchk(3'd5, 8'h02, "R5 retry fail flag");
    wr(3'd1, 8'h01);
    run_tx(-1, -1, -1, s);
    chk("R4 count 0 gives one send", s, 1);
    rdchk(3'd5, 8'h02, "R5 fail with count 0");
    wr(3'd1, 8'h06);
    run_tx(-1, -1, -1, s);
    chk("R4 retries disabled one send", s, 1);
    rdchk(3'd5, 8'h02, "R5 fail with retries off");
    wr(3'd1, 8'h07);

    // R6 collisions
    run_tx(-1, 0, -1, s);
    chk("R6 collision while sending no retry", s, 1);
    rdchk(3'd5, 8'h04, "R6 collision flag send");
    run_tx(-1, 5, -1, s);
    chk("R6 collision in ack wait no retry", s, 1);
    rdchk(3'd5, 8'h04, "R6 collision flag ack wait");

    // R2 start ignored while busy
    wr(3'd0, 8'h01);
    frame_sent = 1; step(); frame_sent = 0;
    wr(3'd0, 8'h01);
    s = 0;
    for (int n = 0; n < 5; n++) begin
      if (tx_start) s++;
      step();
    end
    chk("R2 go ignored while busy", s, 0);
    gcrc_rx = 1; step(); gcrc_rx = 0;
    rdchk(3'd5, 8'h01, "R2 original transfer completes");

    // R7 hard reset send, then frozen
    wr(3'd1, 8'h47);
    chk("R7 hr_send pulse", hr_send, 1);
    step();
    chk("R7 hr_send single cycle", hr_send, 0);
    repeat (3) step();
    hr_done = 1; step(); hr_done = 0;
    rdchk(3'd5, 8'h08, "R7 hard reset sent flag");
    run_tx(3, -1, -1, s);
    chk("R8 frozen after hard reset sent", s, 0);
    wr(3'd2, 8'h02);
    run_tx(3, -1, -1, s);
    chk("R8 resumes after protocol reset", s, 1);
    rdchk(3'd5, 8'h01, "R8 ack after resume");

    // R8 hard reset received
    run_tx(-1, -1, 4, s);
    chk("R8 no retry after hard reset received", s, 1);
    rdchk(3'd5, 8'h10, "R8 hard reset received flag");
    run_tx(-1, -1, -1, s);
    chk("R8 frozen after received hard reset", s, 0);
    wr(3'd2, 8'h02);

    // R9 acknowledgment sent
    ack_done = 1; step(); ack_done = 0;
    rdchk(3'd6, 8'h01, "R9 ack sent flag");

    // R10 clear collides with new event
    reg_rd = 1; reg_addr = 3'd6; ack_done = 1;
    step();
    reg_rd = 0; ack_done = 0;
    chk("R10 read returns pre-event value", reg_rdata, 8'h00);
    rdchk(3'd6, 8'h01, "R10 coincident event kept");
    rdchk(3'd6, 8'h00, "R10 cleared by read");

    // R11 per-bit mask and global disable
    wr(3'd4, 8'h01);
    ack_done = 1; step(); ack_done = 0;
    step();
    chk("R11 masked bit keeps irq high", irq_n, 1);
    rdchk(3'd6, 8'h01, "R11 masked event still latched");
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h20);
    ack_done = 1; step(); ack_done = 0;
    step();
    chk("R11 global disable keeps irq high", irq_n, 1);
    wr(3'd0, 8'h00);
    step();
    chk("R11 irq low after enable", irq_n, 0);
    rdchk(3'd6, 8'h01, "R11 pending under global disable");
    step();
    chk("R11 irq high cycle after clear", irq_n, 1);

    repeat (3) step();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule